// File: doc/BRIEF.md
# Gapless Fieldbus Frame Transmitter

This block puts a whole datagram onto an RS485 line as one unbroken stream of 11-bit characters. A host first fills an internal byte buffer through a simple write port, presents a byte count and a bit-period divisor, and then pulses `start`. The block latches the count and divisor. It watches the receive side of the bus until the line has been high for eleven whole bit periods in a row. It then raises the transceiver driver enable one bit period ahead of the first start bit and clocks every character out back to back, with no idle time between characters.

Each character has a low start bit, eight data bits sent least significant first, an even-parity bit and a high stop bit. When the stop bit of the last byte has been on the line for its full period, the block releases the driver and pulses `done` for one clock. A start request with a count of zero or above 244 is refused: the line is not driven and an error flag is raised instead.

Top module: `gapless_frame_tx`

## Requirements
- R1: Each character is 11 bits and each bit lasts exactly `bit_div` clocks. Bit 0 is the start bit (0). Bits 1 to 8 are the data byte, least significant bit first. Bit 9 is parity. Bit 10 is the stop bit (1).
- R2: The parity bit (bit 9) equals the XOR of the eight data bits, so the data and parity bits together hold an even number of ones.
- R3: The start bit of every following character comes in the clock right after the previous stop bit's period ends. A frame of N bytes occupies exactly 11·N·`bit_div` clocks after the lead bit.
- R4: After an accepted start, the driver stays off until `line_in` has been sampled high on 11·`bit_div` consecutive clocks. Any low sample restarts that count.
- R5: `drv_en` rises exactly one bit period before the first start bit, and `tx_out` is 1 during that period. `drv_en` falls in the clock after the last stop bit's period ends. Whenever `drv_en` is low, `tx_out` is 1.
- R6: `busy` is high from the clock after an accepted start until the frame ends. `done` is high for exactly one clock, the first clock in which `busy` and `drv_en` are low again.
- R7: A `start` pulse while `busy` is high has no effect: the frame in progress keeps its length, divisor, data and timing.
- R8: A start with `frame_len` equal to 0 or greater than 244 is rejected: `len_err` becomes 1, `busy` and `drv_en` stay low and `tx_out` stays 1. The next accepted start clears `len_err`.
- R9: Buffer entries 0 to 243 are written through `wr_en`/`wr_addr`/`wr_data`. A frame of the maximum length, 244 bytes, is sent whole and without gaps.
- R10: A `bit_div` of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Buffer write strobe |
| wr_addr | input | 8 | Buffer write index |
| wr_data | input | 8 | Buffer write byte |
| frame_len | input | 8 | Byte count, latched on start |
| bit_div | input | 12 | Clocks per bit, latched on start |
| start | input | 1 | Send request |
| line_in | input | 1 | Bus level sensed from the receiver |
| tx_out | output | 1 | Serial data to the line driver |
| drv_en | output | 1 | Line driver enable |
| busy | output | 1 | Frame pending or in progress |
| done | output | 1 | One-clock end-of-frame pulse |
| len_err | output | 1 | Last start request had an invalid length |

## Verification
Frames are sent with random contents, lengths and divisors. Every clock of each frame is compared against a bench model of the line, which shows up any wrong bit order, parity, bit length or inter-character gap. Directed frames add the single-byte and 244-byte extremes, all-zero and all-one bytes, a zero divisor, and low glitches on the bus during the quiet wait, placed early and one clock before the wait would have ended. Together these separate a correct quiet-window restart from one that is off by a clock or that ignores the glitch. A second start issued in the middle of a frame, with a different length and divisor, and start requests with lengths 0 and 245, show that those requests leave the line alone.

// File: rtl/gft_pkg.sv
package gft_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_LEAD,
        ST_SEND
    } tx_state_e;

    localparam int CHAR_BITS  = 11;
    localparam int QUIET_BITS = 11;

    // Character in transmit order from bit 0: start, data LSB first, parity, stop
    function automatic logic [CHAR_BITS-1:0] frame_char(input logic [7:0] d);
        return {1'b1, ^d, d, 1'b0};
    endfunction

endpackage

// File: rtl/gft_frame_buf.sv
module gft_frame_buf #(
    parameter int DEPTH = 244,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && (wr_addr < AW'(DEPTH))) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        rd_data = (rd_addr < AW'(DEPTH)) ? mem_q[rd_addr] : 8'h00;
    end
endmodule

// File: rtl/gft_quiet_detect.sv
module gft_quiet_detect #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic          line_in,
    input  logic [CW-1:0] limit,
    output logic          hit
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!arm || !line_in) begin
            cnt_d = '0;
        end else if (cnt_q != limit) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit = arm && line_in && (cnt_q == limit - 1'b1);
endmodule

// File: rtl/gapless_frame_tx.sv
module gapless_frame_tx
    import gft_pkg::*;
#(
    parameter int MAX_LEN = 244,
    parameter int DIV_W   = 12,
    parameter int LEN_W   = $clog2(MAX_LEN + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LEN_W-1:0] wr_addr,
    input  logic [7:0]       wr_data,
    input  logic [LEN_W-1:0] frame_len,
    input  logic [DIV_W-1:0] bit_div,
    input  logic             start,
    input  logic             line_in,
    output logic             tx_out,
    output logic             drv_en,
    output logic             busy,
    output logic             done,
    output logic             len_err
);
    localparam int QW = DIV_W + 4;
    localparam int BW = $clog2(CHAR_BITS);

    typedef struct packed {
        tx_state_e              state;
        logic [DIV_W-1:0]       div;
        logic [DIV_W-1:0]       cnt;
        logic [BW-1:0]          bidx;
        logic [LEN_W-1:0]       idx;
        logic [LEN_W-1:0]       len;
        logic [CHAR_BITS-1:0]   shreg;
        logic                   done;
        logic                   err;
    } regs_t;

    regs_t r_d, r_q;

    logic [LEN_W-1:0] rd_addr;
    logic [7:0]       rd_data;
    logic [QW-1:0]    quiet_limit;
    logic             quiet_hit;
    logic             bit_end;

    assign rd_addr     = (r_q.state == ST_LEAD) ? '0 : r_q.idx + 1'b1;
    assign quiet_limit = QW'(r_q.div) * QW'(QUIET_BITS);
    assign bit_end     = (r_q.cnt == r_q.div - 1'b1);

    gft_frame_buf #(.DEPTH(MAX_LEN), .AW(LEN_W)) u_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    gft_quiet_detect #(.CW(QW)) u_quiet (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (r_q.state == ST_WAIT),
        .line_in (line_in),
        .limit   (quiet_limit),
        .hit     (quiet_hit)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    if (frame_len == '0 || frame_len > LEN_W'(MAX_LEN)) begin
                        r_d.err = 1'b1;
                    end else begin
                        r_d.err   = 1'b0;
                        r_d.state = ST_WAIT;
                        r_d.len   = frame_len;
                        r_d.div   = (bit_div == '0) ? DIV_W'(1) : bit_div;
                        r_d.idx   = '0;
                        r_d.cnt   = '0;
                    end
                end
            end
            ST_WAIT: begin
                if (quiet_hit) begin
                    r_d.state = ST_LEAD;
                    r_d.cnt   = '0;
                end
            end
            ST_LEAD: begin
                if (bit_end) begin
                    r_d.state = ST_SEND;
                    r_d.cnt   = '0;
                    r_d.bidx  = '0;
                    r_d.idx   = '0;
                    r_d.shreg = frame_char(rd_data);
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_SEND: begin
                if (bit_end) begin
                    r_d.cnt = '0;
                    if (r_q.bidx == BW'(CHAR_BITS - 1)) begin
                        if (r_q.idx == r_q.len - 1'b1) begin
                            r_d.state = ST_IDLE;
                            r_d.done  = 1'b1;
                        end else begin
                            r_d.idx   = r_q.idx + 1'b1;
                            r_d.bidx  = '0;
                            r_d.shreg = frame_char(rd_data);
                        end
                    end else begin
                        r_d.shreg = {1'b1, r_q.shreg[CHAR_BITS-1:1]};
                        r_d.bidx  = r_q.bidx + 1'b1;
                    end
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.div   <= DIV_W'(1);
            r_q.shreg <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign tx_out  = (r_q.state == ST_SEND) ? r_q.shreg[0] : 1'b1;
    assign drv_en  = (r_q.state == ST_LEAD) || (r_q.state == ST_SEND);
    assign busy    = (r_q.state != ST_IDLE);
    assign done    = r_q.done;
    assign len_err = r_q.err;
endmodule

// File: rtl/gft_checker.sv
module gft_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_out,
    input logic drv_en,
    input logic busy,
    input logic done,
    input logic len_err
);
    AST_LINE_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_en |-> tx_out);                                               // R5
    AST_LEAD_BIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_en) |-> tx_out);                                         // R5
    AST_DONE_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !drv_en && $past(drv_en) && $past(tx_out)));    // R5
    AST_DRIVE_WITHIN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        drv_en |-> busy);                                                  // R6
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                   // R6
    AST_BUSY_ENDS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);                                             // R6
    AST_REJECT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(len_err) |-> (!busy && !drv_en));                            // R8
endmodule

bind gapless_frame_tx gft_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_out  (tx_out),
    .drv_en  (drv_en),
    .busy    (busy),
    .done    (done),
    .len_err (len_err)
);

// File: tb/gapless_frame_tx_bench.sv
`timescale 1ns/100ps
module gapless_frame_tx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  frame_len = '0;
    logic [11:0] bit_div = 12'd1;
    logic        start = 1'b0;
    logic        line_in = 1'b1;
    logic        tx_out, drv_en, busy, done, len_err;

    int checks = 0;
    int errors = 0;
    logic [7:0] bbuf [244];

    always #2.5 clk = ~clk;

    gapless_frame_tx u_gapless_frame_tx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .frame_len(frame_len), .bit_div(bit_div), .start(start), .line_in(line_in),
        .tx_out(tx_out), .drv_en(drv_en), .busy(busy), .done(done), .len_err(len_err)
    );

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Bit j of a character: 0 start, 1..8 data LSB first, 9 even parity, 10 stop
    function automatic logic char_bit(logic [7:0] d, int j);
        if (j == 0)  return 1'b0;
        if (j == 10) return 1'b1;
        if (j == 9)  return ^d;
        return d[j-1];
    endfunction

    task automatic load_buf(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_addr = 8'(i); wr_data = bbuf[i];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // glitch g > 0 drives line_in low for edge g after the start edge
    task automatic run_frame(int len, int div, int glitch, bit poke, string note);
        int ediv = (div == 0) ? 1 : div;
        int qt   = 11 * ediv + glitch;
        int s0   = qt + ediv;
        int fin  = s0 + 11 * len * ediv;
        int btx = 0, bde = 0, bbz = 0;
        int atx = 0, etx = 0, ktx = 0, ade = 0, ede_v = 0, kde = 0, abz = 0, ebz = 0, kbz = 0;
        string ttx = "R1", tde = "R5";
        @(negedge clk);
        frame_len = 8'(len); bit_div = 12'(div); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(len_err == 1'b0, "R8", {note, " len_err cleared by accepted start"}, int'(len_err), 0);
        for (int k = 0; k <= fin + 1; k++) begin
            logic e_tx, e_de, e_bz, e_dn;
            e_bz = (k < fin);
            e_de = (k >= qt) && (k < fin);
            e_dn = (k == fin);
            e_tx = 1'b1;
            if (k >= s0 && k < fin) begin
                int bn = (k - s0) / ediv;
                int j  = bn % 11;
                e_tx = char_bit(bbuf[bn / 11], j);
                if (tx_out !== e_tx && btx == 0) begin
                    ttx = (j == 9) ? "R2" : ((j == 0 || j == 10) ? "R3" : "R1");
                end
            end
            if (tx_out !== e_tx) begin
                if (btx == 0) begin atx = int'(tx_out); etx = int'(e_tx); ktx = k; end
                btx++;
            end
            if (drv_en !== e_de) begin
                if (bde == 0) begin
                    ade = int'(drv_en); ede_v = int'(e_de); kde = k;
                    tde = (k < qt) ? "R4" : "R5";
                end
                bde++;
            end
            if (busy !== e_bz || done !== e_dn) begin
                if (bbz == 0) begin abz = {busy, done}; ebz = {e_bz, e_dn}; kbz = k; end
                bbz++;
            end
            line_in = !(glitch > 0 && k + 1 == glitch);
            if (poke && k == 3) begin start = 1'b1; frame_len = 8'd7; bit_div = 12'(div + 3); end
            if (poke && k == 4) begin start = 1'b0; end
            @(negedge clk);
        end
        line_in = 1'b1;
        check(btx == 0, ttx, $sformatf("%s tx_out at cycle %0d", note, ktx), atx, etx);
        check(bde == 0, tde, $sformatf("%s drv_en at cycle %0d", note, kde), ade, ede_v);
        check(bbz == 0, "R6", $sformatf("%s {busy,done} at cycle %0d", note, kbz), abz, ebz);
        if (poke) check(btx + bde + bbz == 0, "R7", {note, " frame disturbed by start while busy"},
                        btx + bde + bbz, 0);
    endtask

    task automatic reject(int len);
        int bad = 0;
        @(negedge clk);
        frame_len = 8'(len); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 30; k++) begin
            if (busy || drv_en || !tx_out) bad++;
            @(negedge clk);
        end
        check(len_err == 1'b1, "R8", $sformatf("len_err for length %0d", len), int'(len_err), 1);
        check(bad == 0, "R8", $sformatf("cycles driven for rejected length %0d", len), bad, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R6 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state: R5 R6 R8
        check(tx_out == 1'b1 && drv_en == 1'b0, "R5", "reset line state", {tx_out, drv_en}, 2);
        check(busy == 1'b0 && done == 1'b0, "R6", "reset busy/done", {busy, done}, 0);
        check(len_err == 1'b0, "R8", "reset len_err", int'(len_err), 0);

        // single byte, all zero, divisor 1
        bbuf[0] = 8'h00; load_buf(1);
        run_frame(1, 1, 0, 1'b0, "len1 div1");
        // all ones and one lone bit, divisor 3
        bbuf[0] = 8'hFF; bbuf[1] = 8'h01; bbuf[2] = 8'h80; load_buf(3);
        run_frame(3, 3, 0, 1'b0, "ones div3");
        // R4: bus glitches during the quiet wait, early and at the last clock
        run_frame(3, 2, 7, 1'b0, "R4 early glitch");
        run_frame(3, 2, 21, 1'b0, "R4 late glitch");
        // R10: divisor 0 behaves as 1
        run_frame(3, 0, 0, 1'b0, "R10 div0");
        // R7: start while busy with other length and divisor
        run_frame(3, 2, 0, 1'b1, "R7 poke");
        // R8: invalid lengths, then a valid frame clears the flag
        reject(0);
        reject(245);
        run_frame(2, 1, 0, 1'b0, "R8 recover");
        // R9: full-size datagram
        for (int i = 0; i < 244; i++) bbuf[i] = 8'($urandom);
        load_buf(244);
        run_frame(244, 1, 0, 1'b0, "R9 len244");
        // random frames
        for (int n = 0; n < 8; n++) begin
            int len = 1 + int'($urandom % 40);
            int div = 1 + int'($urandom % 4);
            int gl  = ((n % 3) == 0) ? 1 + int'($urandom % (11 * div - 1)) : 0;
            for (int i = 0; i < len; i++) bbuf[i] = 8'($urandom);
            load_buf(len);
            run_frame(len, div, gl, 1'b0, $sformatf("random %0d", n));
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule